// File: doc/BRIEF.md
# Switching Activity Pattern Generator

This block drives three wide register vectors. Each one switches in its own data-dependent way, so that a measurement of supply current can tell the cost of register bit transitions apart from the cost of the Hamming weight that is stored. The first vector is a one-hot token that rotates toward the MSB. The second is an accumulator that takes the XOR of its old value with the old token, so its weight climbs and then falls. The third is an accumulator that takes the XOR of its old value with the old second vector, so the number of bits that flip on each clock climbs and then falls.

All three registers advance together on every clock where the enable is high. Each new value comes from the current registered value, so one register stage always separates consecutive values. For each vector the block also drives a registered weight count and a registered toggle count. These counts let the user line up any power trace with the switching activity that caused it. The width is a parameter. The default is 4096 bits, and a small width such as 16 suits simulation.

Top module: `switch_pattern_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `vec_rot` becomes 1 (only bit 0 set), `vec_ramp` and `vec_flip` become all zeros, `wt_rot` becomes 1, and every other count becomes 0.
- R2: On an enabled edge, the set bit of `vec_rot` moves one position toward the MSB. From bit WIDTH-1 it wraps to bit 0, so `vec_rot` always has exactly one bit set.
- R3: On an enabled edge, `vec_ramp` takes old `vec_ramp` XOR old `vec_rot`. After n enabled edges from reset, its weight is m for m = n mod 2·WIDTH when m ≤ WIDTH, and 2·WIDTH − m otherwise.
- R4: On an enabled edge, `vec_flip` takes old `vec_flip` XOR old `vec_ramp`, so `tog_flip` after that edge equals the value `wt_ramp` had before it.
- R5: On an edge with `en` low and `rst` low, all three vectors keep their values.
- R6: After an edge with `en` low, all three toggle counts read 0 and the three weight counts keep their values.
- R7: After every edge, each `wt_*` output equals the number of set bits in the vector shown in the same cycle. Each `tog_*` output equals the number of bits of that vector that changed at that edge, so `tog_rot` = 2 and `tog_ramp` = 1 after every enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance all three vectors at this edge |
| vec_rot | output | WIDTH | Rotating one-hot vector |
| vec_ramp | output | WIDTH | Accumulator of the one-hot vector (weight ramp) |
| vec_flip | output | WIDTH | Accumulator of the ramp vector (toggle ramp) |
| wt_rot | output | CNT_W | Set-bit count of `vec_rot` |
| wt_ramp | output | CNT_W | Set-bit count of `vec_ramp` |
| wt_flip | output | CNT_W | Set-bit count of `vec_flip` |
| tog_rot | output | CNT_W | Bits of `vec_rot` changed at the last edge |
| tog_ramp | output | CNT_W | Bits of `vec_ramp` changed at the last edge |
| tog_flip | output | CNT_W | Bits of `vec_flip` changed at the last edge |

CNT_W = $clog2(WIDTH+1).

## Verification
The bench runs the generator with enable held high for more than two full periods of 2·WIDTH edges. This run covers the MSB-to-bit-0 wrap, the top and bottom of the weight ramp, and the point where the toggle ramp turns. It also distinguishes a rotate from a shift that would drop the bit. Runs of enable low are inserted at a rising point and at a falling point of the ramp. These runs show that a hold freezes the vectors and weights while the toggle counts drop to zero, which separates stored weight from switching activity. Every cycle is compared with a closed-form value for the token and the ramp vector, and with a shadow accumulator for the third vector.

// File: rtl/pattern_gen_pkg.sv
package pattern_gen_pkg;

    // Identifies each of the three generated vectors.
    typedef enum logic [1:0] {
        VEC_ROT  = 2'd0,
        VEC_RAMP = 2'd1,
        VEC_FLIP = 2'd2
    } vec_id_e;

    localparam int NUM_VEC = 3;

    // Width needed to hold a count from 0 up to w.
    function automatic int count_width(input int w);
        return $clog2(w + 1);
    endfunction

    // Weight each vector carries right after reset.
    function automatic int reset_weight(input vec_id_e id);
        return (id == VEC_ROT) ? 1 : 0;
    endfunction

endpackage

// File: rtl/pattern_next_state.sv
module pattern_next_state #(
    parameter int WIDTH = 4096
) (
    input  logic             en,
    input  logic [WIDTH-1:0] cur_rot,
    input  logic [WIDTH-1:0] cur_ramp,
    input  logic [WIDTH-1:0] cur_flip,
    output logic [WIDTH-1:0] nxt_rot,
    output logic [WIDTH-1:0] nxt_ramp,
    output logic [WIDTH-1:0] nxt_flip
);

    // Every next value is derived only from the registered current values.
    always_comb begin
        if (en) begin
            nxt_rot  = {cur_rot[WIDTH-2:0], cur_rot[WIDTH-1]};
            nxt_ramp = cur_ramp ^ cur_rot;
            nxt_flip = cur_flip ^ cur_ramp;
        end else begin
            nxt_rot  = cur_rot;
            nxt_ramp = cur_ramp;
            nxt_flip = cur_flip;
        end
    end

endmodule

// File: rtl/activity_counter.sv
module activity_counter #(
    parameter int WIDTH   = 4096,
    parameter int INIT_WT = 0,
    localparam int CNT_W  = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] nxt,
    output logic [CNT_W-1:0] weight,
    output logic [CNT_W-1:0] toggles
);

    logic [CNT_W-1:0] pop_nxt;
    logic [CNT_W-1:0] pop_diff;
    logic [WIDTH-1:0] diff;

    assign diff = cur ^ nxt;

    always_comb begin
        pop_nxt  = '0;
        pop_diff = '0;
        for (int i = 0; i < WIDTH; i++) begin
            pop_nxt  = pop_nxt  + CNT_W'(nxt[i]);
            pop_diff = pop_diff + CNT_W'(diff[i]);
        end
    end

    // Weight follows the value being loaded, so it lines up with the vector.
    // A held vector has nxt == cur, which makes the toggle count zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            weight  <= CNT_W'(INIT_WT);
            toggles <= '0;
        end else begin
            weight  <= pop_nxt;
            toggles <= pop_diff;
        end
    end

    // R7: a weight can change by at most the number of toggled bits
    a_r7_weight_vs_toggle: assert property (@(posedge clk) disable iff (rst)
        ((weight >= $past(weight)) ? (weight - $past(weight)) : ($past(weight) - weight)) <= toggles);

endmodule

// File: rtl/switch_pattern_gen.sv
module switch_pattern_gen
    import pattern_gen_pkg::*;
#(
    parameter int WIDTH  = 4096,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [WIDTH-1:0] vec_rot,
    output logic [WIDTH-1:0] vec_ramp,
    output logic [WIDTH-1:0] vec_flip,
    output logic [CNT_W-1:0] wt_rot,
    output logic [CNT_W-1:0] wt_ramp,
    output logic [CNT_W-1:0] wt_flip,
    output logic [CNT_W-1:0] tog_rot,
    output logic [CNT_W-1:0] tog_ramp,
    output logic [CNT_W-1:0] tog_flip
);

    initial begin
        if (WIDTH < 2) $error("switch_pattern_gen: WIDTH must be at least 2");
        if (CNT_W != count_width(WIDTH)) $error("switch_pattern_gen: count width mismatch");
    end

    logic [WIDTH-1:0] cur [NUM_VEC];
    logic [WIDTH-1:0] nxt [NUM_VEC];
    logic [CNT_W-1:0] wt  [NUM_VEC];
    logic [CNT_W-1:0] tog [NUM_VEC];

    pattern_next_state #(.WIDTH(WIDTH)) u_next (
        .en       (en),
        .cur_rot  (cur[VEC_ROT]),
        .cur_ramp (cur[VEC_RAMP]),
        .cur_flip (cur[VEC_FLIP]),
        .nxt_rot  (nxt[VEC_ROT]),
        .nxt_ramp (nxt[VEC_RAMP]),
        .nxt_flip (nxt[VEC_FLIP])
    );

    // One state register and one activity counter per vector.
    for (genvar g = 0; g < NUM_VEC; g++) begin : g_vec
        localparam vec_id_e ID = vec_id_e'(g);
        localparam logic [WIDTH-1:0] INIT_VAL =
            (ID == VEC_ROT) ? WIDTH'(1) : '0;

        always_ff @(posedge clk) begin
            if (rst) cur[g] <= INIT_VAL;
            else     cur[g] <= nxt[g];
        end

        activity_counter #(
            .WIDTH   (WIDTH),
            .INIT_WT (reset_weight(ID))
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .cur     (cur[g]),
            .nxt     (nxt[g]),
            .weight  (wt[g]),
            .toggles (tog[g])
        );
    end

    assign vec_rot  = cur[VEC_ROT];
    assign vec_ramp = cur[VEC_RAMP];
    assign vec_flip = cur[VEC_FLIP];
    assign wt_rot   = wt[VEC_ROT];
    assign wt_ramp  = wt[VEC_RAMP];
    assign wt_flip  = wt[VEC_FLIP];
    assign tog_rot  = tog[VEC_ROT];
    assign tog_ramp = tog[VEC_RAMP];
    assign tog_flip = tog[VEC_FLIP];

    // R2: the token register always holds exactly one set bit
    a_r2_single_token: assert property (@(posedge clk) disable iff (rst)
        $countones(vec_rot) == 1);

    // R3: the ramp weight moves by exactly one on an enabled edge
    a_r3_ramp_step: assert property (@(posedge clk) disable iff (rst)
        en |=> ((wt_ramp == $past(wt_ramp) + CNT_W'(1)) ||
                (wt_ramp == $past(wt_ramp) - CNT_W'(1))));

    // R4: the flip toggle count equals the ramp weight before the edge
    a_r4_flip_toggles: assert property (@(posedge clk) disable iff (rst)
        en |=> tog_flip == $past(wt_ramp));

    // R5: a disabled edge leaves every vector unchanged
    a_r5_hold_vectors: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(vec_rot) && $stable(vec_ramp) && $stable(vec_flip)));

    // R6: a disabled edge reports no toggles
    a_r6_no_toggles: assert property (@(posedge clk) disable iff (rst)
        !en |=> (tog_rot == '0 && tog_ramp == '0 && tog_flip == '0));

endmodule

// File: tb/tb_switch_pattern_gen.sv
module tb_switch_pattern_gen;

    localparam int W  = 16;
    localparam int CW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [W-1:0]  vec_rot, vec_ramp, vec_flip;
    logic [CW-1:0] wt_rot, wt_ramp, wt_flip, tog_rot, tog_ramp, tog_flip;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    switch_pattern_gen #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .en(en),
        .vec_rot(vec_rot), .vec_ramp(vec_ramp), .vec_flip(vec_flip),
        .wt_rot(wt_rot), .wt_ramp(wt_ramp), .wt_flip(wt_flip),
        .tog_rot(tog_rot), .tog_ramp(tog_ramp), .tog_flip(tog_flip)
    );

    function automatic int popc(input logic [W-1:0] v);
        int s = 0;
        for (int i = 0; i < W; i++) s += int'(v[i]);
        return s;
    endfunction

    // Closed forms in terms of the number of enabled edges since reset.
    function automatic logic [W-1:0] rot_at(input int n);
        return W'(1) << (n % W);
    endfunction

    function automatic logic [W-1:0] ramp_at(input int n);
        int m = n % (2 * W);
        logic [W:0] t;
        if (m <= W) begin
            t = ((W+1)'(1) << m) - (W+1)'(1);
            return t[W-1:0];
        end
        t = ((W+1)'(1) << (m - W)) - (W+1)'(1);
        return ~t[W-1:0];
    endfunction

    function automatic int ramp_wt(input int n);
        int m = n % (2 * W);
        return (m <= W) ? m : 2 * W - m;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int            n_steps = 0;
    logic [W-1:0]  flip_model = '0;
    int            prev_ramp_wt = 0;
    bit            done = 0;

    // Apply one edge with the given enable, then compare 5 ns after it.
    task automatic step(input logic en_v);
        logic [W-1:0] ramp_before;
        ramp_before  = ramp_at(n_steps);
        prev_ramp_wt = ramp_wt(n_steps);
        en = en_v;
        @(posedge clk);
        #5;
        if (en_v) begin
            flip_model = flip_model ^ ramp_before;
            n_steps++;
        end
        chk("R2", "vec_rot", vec_rot, rot_at(n_steps));
        chk("R2", "wt_rot", wt_rot, 1);
        chk("R3", "vec_ramp", vec_ramp, ramp_at(n_steps));
        chk("R3", "wt_ramp", wt_ramp, ramp_wt(n_steps));
        chk("R4", "vec_flip", vec_flip, flip_model);
        chk("R7", "wt_flip", wt_flip, popc(flip_model));
        if (en_v) begin
            chk("R4", "tog_flip", tog_flip, prev_ramp_wt);
            chk("R7", "tog_rot", tog_rot, 2);
            chk("R7", "tog_ramp", tog_ramp, 1);
        end else begin
            chk("R6", "tog_rot", tog_rot, 0);
            chk("R6", "tog_ramp", tog_ramp, 0);
            chk("R6", "tog_flip", tog_flip, 0);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        // R1: reset state
        chk("R1", "vec_rot", vec_rot, 1);
        chk("R1", "vec_ramp", vec_ramp, 0);
        chk("R1", "vec_flip", vec_flip, 0);
        chk("R1", "wt_rot", wt_rot, 1);
        chk("R1", "wt_ramp", wt_ramp, 0);
        chk("R1", "wt_flip", wt_flip, 0);
        chk("R1", "tog_sum", tog_rot + tog_ramp + tog_flip, 0);
        rst = 1'b0;

        // rising part of the ramp, then a hold (R5, R6)
        for (int i = 0; i < W / 2 + 1; i++) step(1'b1);
        begin
            logic [W-1:0] r0, r1, r2;
            r0 = vec_rot; r1 = vec_ramp; r2 = vec_flip;
            for (int i = 0; i < 4; i++) step(1'b0);
            chk("R5", "held vec_rot", vec_rot, r0);
            chk("R5", "held vec_ramp", vec_ramp, r1);
            chk("R5", "held vec_flip", vec_flip, r2);
        end
        // through the peak and into the falling part, then another hold
        for (int i = 0; i < W + 3; i++) step(1'b1);
        for (int i = 0; i < 3; i++) step(1'b0);
        // more than two full periods in total
        for (int i = 0; i < 3 * W; i++) step(1'b1);
        step(1'b0);
        step(1'b1);

        // R1: reset in the middle of a run restores the start state
        rst = 1'b1;
        en  = 1'b1;
        @(posedge clk);
        #5;
        chk("R1", "vec_rot after reset", vec_rot, 1);
        chk("R1", "vec_ramp after reset", vec_ramp, 0);
        chk("R1", "wt_rot after reset", wt_rot, 1);
        chk("R1", "tog_flip after reset", tog_flip, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule